// File: doc/BRIEF.md
# Flash Write Strobe Qualifier

This block is the bus-side front end of a parallel NOR flash model. It watches the active-low chip select, write strobe and output enable pins together with the address and data buses. From them it forms one combined write strobe, which is active only while chip select and write strobe are both low. The address is captured when that combined strobe begins, which is the later of the two falling edges. The data is captured when the strobe ends, which is the earlier of the two rising edges.

Strobes shorter than a minimum width are dropped. Writes are refused while output enable is low or while the `power_good` input is low; `power_good` stands in for supply lockout detection. Each accepted write leaves the block as a single-cycle `wr_valid` pulse, with the captured address and data held on `wr_addr` and `wr_data`. Command decoding downstream consumes these pulses.

The three control pins pass through two-flop synchronizers. The address and data buses are delayed by the same two stages, so that every bus sample lines up with the control sample taken at the same edge. Pulse width is counted in clock samples, and `MIN_PULSE` gives the minimum.

The strobe state machine has three states:
- **ST_IDLE**: no strobe. When the strobe is seen and writes are allowed, it moves to ST_PULSE (*open*: address captured, count = 1). When the strobe is seen while writes are refused, it moves to ST_BLOCKED (*refuse*).
- **ST_PULSE**: counting, saturating at `MIN_PULSE`. When the strobe ends with count ≥ `MIN_PULSE` and writes still allowed, it returns to ST_IDLE (*accept*: pulse issued). When the strobe ends under any other condition, it returns to ST_IDLE (*drop*). When output enable or `power_good` falls during the strobe, it moves to ST_BLOCKED (*cancel*).
- **ST_BLOCKED**: waits for the strobe to end, then returns to ST_IDLE (*release*).

Top module: `flash_wstrobe_qual`

## Requirements
- R1: No write is produced unless `ce_n` and `we_n` are low together; either one low by itself never causes a `wr_valid` pulse.
- R2: `wr_addr` carries the address present when the combined strobe begins (the later falling edge); address changes later in the strobe are ignored.
- R3: `wr_data` carries the data present when the combined strobe ends (the earlier rising edge); data seen earlier in the strobe is ignored.
- R4: A strobe seen low for fewer than `MIN_PULSE` clock samples (default 2) gives no write; one seen for `MIN_PULSE` or more samples gives exactly one write.
- R5: A strobe that begins while `oe_n` is low gives no write.
- R6: A strobe that begins while `power_good` is low gives no write.
- R7: If `oe_n` or `power_good` goes low while a strobe is in progress, that strobe is cancelled and gives no write.
- R8: `wr_valid` is high for exactly one clock cycle per accepted strobe. It rises on the third rising clock edge after the strobe's ending edge reaches the pins.
- R9: Reset clears `wr_valid`, `wr_addr` and `wr_data` to 0 and abandons any strobe in progress. Between accepted writes, `wr_addr` and `wr_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| power_good | input | 1 | High when the supply is above lockout, synchronous |
| addr | input | AW | Address bus |
| data | input | DW | Data bus |
| wr_valid | output | 1 | One-cycle pulse per accepted write |
| wr_addr | output | AW | Address captured at the strobe start |
| wr_data | output | DW | Data captured at the strobe end |

## Verification
A state machine stuck in ST_BLOCKED or ST_PULSE shows up at the ports as a missing or extra `wr_valid` pulse on the very next strobe. A wrong width count shows up as short strobes being accepted or long ones being dropped, within three cycles of the strobe ending. Address or data sampled at the wrong boundary shows as a mismatch on `wr_addr` or `wr_data` in the same cycle the pulse appears. The bench changes the address partway through each strobe and changes the data just after the strobe starts, so that a wrong capture point is caught.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PULSE   = 2'd1,
        ST_BLOCKED = 2'd2
    } wsq_state_e;

    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/wsq_delay.sv
// Multi-stage register chain; used both as the control synchronizer
// and as the matching bus delay.
module wsq_delay #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wsq_fsm.sv
module wsq_fsm
    import wsq_pkg::*;
#(
    parameter int AW        = 20,
    parameter int DW        = 16,
    parameter int MIN_PULSE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          allow,
    input  logic [AW-1:0] addr_d,
    input  logic [DW-1:0] data_d,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output wsq_state_e    state
);
    localparam int CW = $clog2(MIN_PULSE + 1);

    wsq_state_e    nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic [AW-1:0] lat_addr;
    logic          open_w, accept;

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        open_w  = 1'b0;
        accept  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (strobe) begin
                    cnt_nxt = CW'(1);
                    if (allow) begin
                        open_w = 1'b1;            // open
                        nxt    = ST_PULSE;
                    end else begin
                        nxt    = ST_BLOCKED;      // refuse
                    end
                end
            end
            ST_PULSE: begin
                if (!strobe) begin
                    accept = allow && (cnt >= CW'(MIN_PULSE)); // accept / drop
                    nxt    = ST_IDLE;
                end else if (!allow) begin
                    nxt    = ST_BLOCKED;          // cancel
                end else if (cnt < CW'(MIN_PULSE)) begin
                    cnt_nxt = cnt + CW'(1);
                end
            end
            ST_BLOCKED: begin
                if (!strobe) nxt = ST_IDLE;       // release
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            lat_addr <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            if (open_w) lat_addr <= addr_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= accept;
            if (accept) begin
                wr_addr <= lat_addr;
                wr_data <= data_d;
            end
        end
    end
endmodule

// File: rtl/flash_wstrobe_qual.sv
module flash_wstrobe_qual
    import wsq_pkg::*;
#(
    parameter int AW        = 20,
    parameter int DW        = 16,
    parameter int MIN_PULSE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          power_good,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    logic          ce_s, we_s, oe_s;
    logic [AW-1:0] addr_d;
    logic [DW-1:0] data_d;
    logic          strobe_s, allow_s;
    wsq_state_e    fsm_state;

    wsq_delay #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_ctrl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ce_n, we_n, oe_n}), .q({ce_s, we_s, oe_s})
    );

    wsq_delay #(.W(AW + DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_dly (
        .clk(clk), .rst_n(rst_n),
        .d({addr, data}), .q({addr_d, data_d})
    );

    assign strobe_s = !ce_s && !we_s;
    assign allow_s  = oe_s && power_good;

    wsq_fsm #(.AW(AW), .DW(DW), .MIN_PULSE(MIN_PULSE)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .strobe(strobe_s), .allow(allow_s),
        .addr_d(addr_d), .data_d(data_d),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .state(fsm_state)
    );
endmodule

// File: rtl/wsq_chk.sv
module wsq_chk
    import wsq_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          power_good,
    input  logic          oe_s,
    input  logic          strobe_s,
    input  wsq_state_e    fsm_state,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R1
    valid_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !$past(strobe_s));

    // R6
    valid_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(power_good));

    // R5
    valid_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(oe_s));

    // R7
    blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_BLOCKED) |=> !wr_valid);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> ($stable(wr_addr) && $stable(wr_data)));
endmodule

bind flash_wstrobe_qual wsq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .power_good(power_good), .oe_s(oe_s),
    .strobe_s(strobe_s), .fsm_state(fsm_state), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/flash_wstrobe_qual_bench.sv
`timescale 1ns/1ps
module flash_wstrobe_qual_bench;
    localparam int AW = 20;
    localparam int DW = 16;

    typedef struct packed {
        logic          ce_first;   // 1: CE falls first
        logic          ce_up;      // 1: CE rises first
        logic [3:0]    width;      // samples with both low
        logic          oe_lvl;
        logic          pg;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 4'd3, 1'b1, 1'b1, 20'h12345, 16'hA5C3, 1'b1},
        '{1'b1, 1'b1, 4'd2, 1'b1, 1'b1, 20'h0ABCD, 16'h1234, 1'b1},
        '{1'b0, 1'b1, 4'd5, 1'b1, 1'b1, 20'hFFFFF, 16'h0000, 1'b1},
        '{1'b1, 1'b0, 4'd1, 1'b1, 1'b1, 20'h55555, 16'hBEEF, 1'b0},
        '{1'b0, 1'b0, 4'd4, 1'b0, 1'b1, 20'h2AAAA, 16'hCAFE, 1'b0},
        '{1'b1, 1'b1, 4'd4, 1'b1, 1'b0, 20'h33333, 16'hF00D, 1'b0},
        '{1'b1, 1'b0, 4'd8, 1'b1, 1'b1, 20'h00001, 16'hFFFF, 1'b1},
        '{1'b0, 1'b1, 4'd1, 1'b1, 1'b1, 20'h70707, 16'h7777, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, power_good = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;

    always #2 clk = ~clk;

    flash_wstrobe_qual #(.AW(AW), .DW(DW), .MIN_PULSE(2)) u_flash_wstrobe_qual (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .power_good(power_good), .addr(addr), .data(data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(negedge clk) if (wr_valid) pulses++;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic nclk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v);
        int p0;
        p0 = pulses;
        oe_n = v.oe_lvl; power_good = v.pg;
        nclk(1);
        if (v.ce_first) ce_n = 1'b0; else we_n = 1'b0;
        addr = ~v.a;
        nclk(2);
        if (v.ce_first) we_n = 1'b0; else ce_n = 1'b0;
        addr = v.a; data = ~v.d;
        nclk(1);
        addr = ~v.a; data = v.d;
        if (v.width > 1) nclk(int'(v.width) - 1);
        if (v.ce_up) ce_n = 1'b1; else we_n = 1'b1;
        nclk(2);
        ce_n = 1'b1; we_n = 1'b1;
        nclk(6);
        data = ~v.d; oe_n = 1'b1; power_good = 1'b1;
        nclk(2);
        check("R4/R5/R6 pulse count", pulses - p0, {31'b0, v.exp});
        if (v.exp) begin
            check("R2 address at strobe start", wr_addr, v.a);
            check("R3 data at strobe end", wr_data, v.d);
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int p0;
        logic [AW-1:0] keep_a;
        logic [DW-1:0] keep_d;
        nclk(3);
        // R9 reset state
        check("R9 reset wr_valid", wr_valid, 0);
        check("R9 reset wr_addr", wr_addr, 0);
        check("R9 reset wr_data", wr_data, 0);
        rst_n = 1'b1;
        nclk(3);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1: one control alone
        p0 = pulses;
        we_n = 1'b0; addr = 20'h11111; nclk(6); we_n = 1'b1; nclk(6);
        ce_n = 1'b0; nclk(6); ce_n = 1'b1; nclk(6);
        check("R1 single control no write", pulses - p0, 0);

        // R8: exact latency and single cycle
        addr = 20'h4C4C4; data = 16'h9A9A;
        ce_n = 1'b0; we_n = 1'b0; nclk(3);
        ce_n = 1'b1; we_n = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R8 not yet valid", wr_valid, 0);
        @(negedge clk);
        check("R8 valid on third edge", wr_valid, 1);
        check("R8 address", wr_addr, 20'h4C4C4);
        @(negedge clk);
        check("R8 valid one cycle", wr_valid, 0);
        nclk(4);
        keep_a = wr_addr; keep_d = wr_data;

        // R7: OE falls during strobe
        p0 = pulses;
        addr = 20'h0F0F0; data = 16'h5555;
        ce_n = 1'b0; we_n = 1'b0; nclk(3);
        oe_n = 1'b0; nclk(3);
        ce_n = 1'b1; we_n = 1'b1; nclk(3); oe_n = 1'b1; nclk(6);
        check("R7 oe cancel", pulses - p0, 0);
        check("R9 hold wr_addr", wr_addr, keep_a);
        check("R9 hold wr_data", wr_data, keep_d);

        // R7: power_good drops during strobe
        p0 = pulses;
        ce_n = 1'b0; we_n = 1'b0; nclk(3);
        power_good = 1'b0; nclk(3);
        ce_n = 1'b1; we_n = 1'b1; nclk(3); power_good = 1'b1; nclk(6);
        check("R7 power cancel", pulses - p0, 0);

        // R9: reset abandons a strobe in progress
        p0 = pulses;
        ce_n = 1'b0; we_n = 1'b0; nclk(4);
        rst_n = 1'b0; nclk(1);
        ce_n = 1'b1; we_n = 1'b1; nclk(3);
        rst_n = 1'b1; nclk(8);
        check("R9 reset abandons strobe", pulses - p0, 0);
        check("R9 reset clears wr_addr", wr_addr, 0);
        check("R9 reset clears wr_data", wr_data, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule